// File: doc/BRIEF.md
# Power-Rail Sequence Order Recorder

This block watches a set of supply rails while they come up and records, for each one, the position it took in the power-up order and the time at which it arrived. A rising edge on the activation input opens a recording window of fixed length. During that window, each rail that reaches its selected threshold receives an order tag and a timestamp. The tag is compared with an expected order value that the host supplies, and a mismatch can pull down an active-low interrupt.

The host reads the logs and acknowledges them. Ready flags show that a log holds data the host has not yet acknowledged. Sticky overwrite flags show that a new window began while unread data was still pending. Tag logs and timestamp logs each have their own overwrite policy. When a policy protects unread data, the new window writes nothing to that log, and for blocked tags no order comparison is made. When the window closes, a two-bit phase field reports whether every rail arrived in its expected position.

The threshold-crossed inputs are levels that are already synchronous to the block clock. A level is taken into account in every cycle of the window until the rail has been tagged.

Top module: `rail_seq_recorder`

## Requirements
- R1: A rising edge of `act_i` sampled at a clock edge starts a window at that edge. `rec_active_o` becomes 1, `phase_o` becomes 00, the order count becomes 0, the timer restarts at 0 and every rail becomes untagged. A rising edge inside an open window restarts it in the same way.
- R2: A rail is tagged at the first edge after the window start at which its selected crossing input is high. `thr_sel_i` bit 1 selects `off_cross_i` and bit 0 selects `uv_cross_i`. The unselected input has no effect, and a rail is tagged at most once per window.
- R3: The tag is the order count held before the edge. Rails tagged at the same edge share one tag, and the count then advances by exactly one.
- R4: The timestamp is the number of edges after the window-start edge, minus one, so the first edge of the window stores 0. The upper TS_W/2 bits of the timestamp appear on `ts_hi_o` and the lower TS_W/2 bits on `ts_lo_o`. Rail i occupies slice i of each flattened output.
- R5: At a window start, if `tag_rdy_o` is 1, then `tag_ovf_o` is set. Tags may be written in the new window only if `tag_ow_en_i` is 1 or `tag_rdy_o` was 0. When writing is allowed, every tag log is reset to all ones at the window start. When writing is blocked, the tag logs keep their values.
- R6: The rule of R5 applies to timestamps, using `ts_ow_en_i`, `ts_rdy_o` and `ts_ovf_o`. When writing is allowed, the timestamp logs are reset to 0 at the window start.
- R7: A ready flag becomes 1 at the edge where its log is written. It clears on its acknowledge strobe, and a write in the same cycle wins over the acknowledge. An overwrite flag stays set until its clear strobe, and setting wins over clearing.
- R8: A written tag that differs from the rail's `exp_tag_i` slice sets that rail's mismatch. All mismatches clear at a window start. A blocked tag is not compared. `irq_n_o` is 0 exactly when `seq_irq_en_i` is 1 and any mismatch is set.
- R9: After TIMEOUT_CYC edges in the window, `rec_active_o` falls and no further rails are tagged. One edge later, `phase_o` becomes 01 if every rail is tagged and none mismatches, or 10 otherwise. Mismatches and the interrupt persist after the window closes.
- R10: While reset is held, all flags are 0, `phase_o` is 00, tag logs are all ones and timestamps are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Activation level; its rising edge opens a window |
| uv_cross_i | input | N_RAILS | Per-rail undervoltage-threshold crossed level |
| off_cross_i | input | N_RAILS | Per-rail off-threshold crossed level |
| thr_sel_i | input | N_RAILS | Per-rail threshold select (1 = off threshold) |
| tag_ow_en_i | input | 1 | Allow overwriting unread tag logs |
| ts_ow_en_i | input | 1 | Allow overwriting unread timestamp logs |
| exp_tag_i | input | N_RAILS*TAG_W | Expected order per rail, rail i at slice i |
| seq_irq_en_i | input | 1 | Sequence interrupt enable |
| tag_ack_i | input | 1 | Host acknowledge of tag logs |
| ts_ack_i | input | 1 | Host acknowledge of timestamp logs |
| tag_ovf_clr_i | input | 1 | Clear tag overwrite flag |
| ts_ovf_clr_i | input | 1 | Clear timestamp overwrite flag |
| rec_active_o | output | 1 | Recording window open |
| phase_o | output | 2 | 00 recording, 01 good order, 10 bad or missing order |
| tag_log_o | output | N_RAILS*TAG_W | Per-rail order tags |
| ts_hi_o | output | N_RAILS*TS_W/2 | Per-rail timestamp upper half |
| ts_lo_o | output | N_RAILS*TS_W/2 | Per-rail timestamp lower half |
| tag_rdy_o | output | 1 | Unacknowledged tag data present |
| ts_rdy_o | output | 1 | Unacknowledged timestamp data present |
| tag_ovf_o | output | 1 | Tag window started over unread data |
| ts_ovf_o | output | 1 | Timestamp window started over unread data |
| irq_n_o | output | 1 | Active-low sequence interrupt |

## Verification
A wrong order count or a wrong rule for sharing tags shows on `tag_log_o` one edge after the crossing. A timer that is off by one shows on the timestamp slices at the same edge. A stale or wrong write permission shows up at the next window start: either the tags are reset when they should not be, or they are not reset when they should be. It also shows as `irq_n_o` falling on a blocked window. A missed close or a bad verdict shows on `phase_o` within TIMEOUT_CYC+1 edges of the start, so every internal fault reaches a port within one window.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

  typedef enum logic [1:0] {
    PH_RECORD = 2'b00,
    PH_GOOD   = 2'b01,
    PH_BAD    = 2'b10
  } seq_phase_e;

  // A log may be written in a window if overwrite is on or nothing is pending.
  function automatic logic gate_write(input logic ow_en, input logic pending);
    return ow_en | ~pending;
  endfunction

  // Threshold selection: sel=1 takes the off threshold.
  function automatic logic pick_cross(input logic sel, input logic uv, input logic off);
    return sel ? off : uv;
  endfunction

  function automatic seq_phase_e seq_verdict(input logic all_tagged, input logic any_bad);
    return (all_tagged && !any_bad) ? PH_GOOD : PH_BAD;
  endfunction

endpackage

// File: rtl/rsr_window_ctrl.sv
module rsr_window_ctrl
  import rsr_pkg::*;
#(
  parameter int N_RAILS     = 4,
  parameter int TAG_W       = 4,
  parameter int TS_W        = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             any_event_i,
  input  logic             all_tagged_i,
  input  logic             any_mismatch_i,
  output logic             win_start_o,
  output logic             rec_active_o,
  output logic [TAG_W-1:0] cnt_o,
  output logic [TS_W-1:0]  timer_o,
  output logic [1:0]       phase_o
);
  localparam logic [TS_W-1:0] LAST_TICK = TS_W'(TIMEOUT_CYC - 1);

  logic       act_q;
  logic       close_q;
  logic       timeout_w;
  seq_phase_e phase_q;

  assign win_start_o = act_i & ~act_q;
  assign timeout_w   = rec_active_o && (timer_o == LAST_TICK);
  assign phase_o     = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q        <= 1'b0;
      close_q      <= 1'b0;
      rec_active_o <= 1'b0;
      cnt_o        <= '0;
      timer_o      <= '0;
      phase_q      <= PH_RECORD;
    end else begin
      act_q <= act_i;
      if (win_start_o) begin
        rec_active_o <= 1'b1;
        close_q      <= 1'b0;
        cnt_o        <= '0;
        timer_o      <= '0;
        phase_q      <= PH_RECORD;
      end else begin
        if (timeout_w) begin
          rec_active_o <= 1'b0;
          close_q      <= 1'b1;
        end else if (rec_active_o) begin
          timer_o <= timer_o + TS_W'(1);
        end
        if (close_q) begin
          close_q <= 1'b0;
          phase_q <= seq_verdict(all_tagged_i, any_mismatch_i);
        end
        if (any_event_i) cnt_o <= cnt_o + TAG_W'(1);
      end
    end
  end

  AST_RISE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_o |=> (rec_active_o && cnt_o == '0 && timer_o == '0 && phase_o == 2'b00)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_o) <= N_RAILS)); // R3
  AST_TIMEOUT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_w && !win_start_o) |=> !rec_active_o); // R9
  AST_VERDICT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (close_q && !win_start_o) |=> (phase_o != 2'b00)); // R9

endmodule

// File: rtl/rsr_log_flags.sv
module rsr_log_flags
  import rsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic win_start_i,
  input  logic ow_en_i,
  input  logic wr_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic grant_o,
  output logic allow_o,
  output logic rdy_o,
  output logic ovf_o
);
  assign grant_o = gate_write(ow_en_i, rdy_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_o <= 1'b0;
      rdy_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (win_start_i) allow_o <= grant_o;
      if (wr_i)        rdy_o <= 1'b1;
      else if (ack_i)  rdy_o <= 1'b0;
      if (win_start_i && rdy_o) ovf_o <= 1'b1;
      else if (clr_i)           ovf_o <= 1'b0;
    end
  end

  AST_RDY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> rdy_o); // R7
  AST_OVF_ON_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start_i && rdy_o) |=> ovf_o); // R5
  AST_NO_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> allow_o); // R5

endmodule

// File: rtl/rsr_rail_log.sv
module rsr_rail_log
  import rsr_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int TS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_start_i,
  input  logic             rec_active_i,
  input  logic             thr_sel_i,
  input  logic             uv_cross_i,
  input  logic             off_cross_i,
  input  logic [TAG_W-1:0] cnt_i,
  input  logic [TS_W-1:0]  timer_i,
  input  logic [TAG_W-1:0] exp_i,
  input  logic             tag_grant_i,
  input  logic             ts_grant_i,
  input  logic             tag_allow_i,
  input  logic             ts_allow_i,
  output logic             event_o,
  output logic             tagged_o,
  output logic             mismatch_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [TS_W-1:0]  ts_o
);
  assign event_o = rec_active_i & pick_cross(thr_sel_i, uv_cross_i, off_cross_i)
                   & ~tagged_o & ~win_start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tagged_o   <= 1'b0;
      mismatch_o <= 1'b0;
      tag_o      <= '1;
      ts_o       <= '0;
    end else if (win_start_i) begin
      tagged_o   <= 1'b0;
      mismatch_o <= 1'b0;
      if (tag_grant_i) tag_o <= '1;
      if (ts_grant_i)  ts_o  <= '0;
    end else if (event_o) begin
      tagged_o <= 1'b1;
      if (tag_allow_i) begin
        tag_o      <= cnt_i;
        mismatch_o <= (cnt_i != exp_i);
      end
      if (ts_allow_i) ts_o <= timer_i;
    end
  end

  AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tagged_o && !win_start_i) |=> $stable(tag_o)); // R2
  AST_BLOCKED_NO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_allow_i |-> !mismatch_o); // R8
  AST_IDLE_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_active_i && !win_start_i) |=> $stable(tagged_o)); // R9

endmodule

// File: rtl/rail_seq_recorder.sv
module rail_seq_recorder
  import rsr_pkg::*;
#(
  parameter int N_RAILS     = 4,
  parameter int TAG_W       = 4,
  parameter int TS_W        = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      act_i,
  input  logic [N_RAILS-1:0]        uv_cross_i,
  input  logic [N_RAILS-1:0]        off_cross_i,
  input  logic [N_RAILS-1:0]        thr_sel_i,
  input  logic                      tag_ow_en_i,
  input  logic                      ts_ow_en_i,
  input  logic [N_RAILS*TAG_W-1:0]  exp_tag_i,
  input  logic                      seq_irq_en_i,
  input  logic                      tag_ack_i,
  input  logic                      ts_ack_i,
  input  logic                      tag_ovf_clr_i,
  input  logic                      ts_ovf_clr_i,
  output logic                      rec_active_o,
  output logic [1:0]                phase_o,
  output logic [N_RAILS*TAG_W-1:0]  tag_log_o,
  output logic [N_RAILS*TS_W/2-1:0] ts_hi_o,
  output logic [N_RAILS*TS_W/2-1:0] ts_lo_o,
  output logic                      tag_rdy_o,
  output logic                      ts_rdy_o,
  output logic                      tag_ovf_o,
  output logic                      ts_ovf_o,
  output logic                      irq_n_o
);
  localparam int HALF_W = TS_W / 2;

  logic               win_start;
  logic [TAG_W-1:0]   cnt;
  logic [TS_W-1:0]    timer;
  logic [N_RAILS-1:0] rail_ev;
  logic [N_RAILS-1:0] rail_tagged;
  logic [N_RAILS-1:0] rail_bad;
  logic               any_event;
  logic               tag_wr;
  logic               ts_wr;
  logic               tag_grant, ts_grant;
  logic               tag_allow, ts_allow;

  assign any_event = |rail_ev;
  assign tag_wr    = any_event & tag_allow;
  assign ts_wr     = any_event & ts_allow;
  assign irq_n_o   = ~(seq_irq_en_i & (|rail_bad));

  rsr_window_ctrl #(
    .N_RAILS(N_RAILS), .TAG_W(TAG_W), .TS_W(TS_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .act_i(act_i),
    .any_event_i(any_event), .all_tagged_i(&rail_tagged), .any_mismatch_i(|rail_bad),
    .win_start_o(win_start), .rec_active_o(rec_active_o),
    .cnt_o(cnt), .timer_o(timer), .phase_o(phase_o)
  );

  rsr_log_flags u_tag_flags (
    .clk(clk), .rst_n(rst_n), .win_start_i(win_start), .ow_en_i(tag_ow_en_i),
    .wr_i(tag_wr), .ack_i(tag_ack_i), .clr_i(tag_ovf_clr_i),
    .grant_o(tag_grant), .allow_o(tag_allow), .rdy_o(tag_rdy_o), .ovf_o(tag_ovf_o)
  );

  rsr_log_flags u_ts_flags (
    .clk(clk), .rst_n(rst_n), .win_start_i(win_start), .ow_en_i(ts_ow_en_i),
    .wr_i(ts_wr), .ack_i(ts_ack_i), .clr_i(ts_ovf_clr_i),
    .grant_o(ts_grant), .allow_o(ts_allow), .rdy_o(ts_rdy_o), .ovf_o(ts_ovf_o)
  );

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    logic [TS_W-1:0] ts_full;
    rsr_rail_log #(.TAG_W(TAG_W), .TS_W(TS_W)) u_rail (
      .clk(clk), .rst_n(rst_n), .win_start_i(win_start), .rec_active_i(rec_active_o),
      .thr_sel_i(thr_sel_i[g]), .uv_cross_i(uv_cross_i[g]), .off_cross_i(off_cross_i[g]),
      .cnt_i(cnt), .timer_i(timer), .exp_i(exp_tag_i[g*TAG_W +: TAG_W]),
      .tag_grant_i(tag_grant), .ts_grant_i(ts_grant),
      .tag_allow_i(tag_allow), .ts_allow_i(ts_allow),
      .event_o(rail_ev[g]), .tagged_o(rail_tagged[g]), .mismatch_o(rail_bad[g]),
      .tag_o(tag_log_o[g*TAG_W +: TAG_W]), .ts_o(ts_full)
    );
    assign ts_hi_o[g*HALF_W +: HALF_W] = ts_full[TS_W-1 -: HALF_W];
    assign ts_lo_o[g*HALF_W +: HALF_W] = ts_full[HALF_W-1:0];
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> seq_irq_en_i); // R8

endmodule

// File: tb/tb_rail_seq_recorder.sv
module tb_rail_seq_recorder;
  localparam int N = 4, TW = 4, SW = 16, TO = 64, HW = SW / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic act = 0, tow = 0, sow = 0, ien = 1, tack = 0, sack = 0, tclr = 0, sclr = 0;
  logic [N-1:0] uv = '0, off = '0, sel = '0;
  logic [N*TW-1:0] expv;
  logic rec, trdy, srdy, tovf, sovf, irqn;
  logic [1:0] ph;
  logic [N*TW-1:0] tags;
  logic [N*HW-1:0] tshi, tslo;

  int n_run = 0, n_fail = 0, cyc = 0;

  // reference model state
  int m_actq, m_rec, m_cnt, m_tmr, m_ph, m_close, m_tal, m_sal, m_trdy, m_srdy, m_tovf, m_sovf;
  int m_tagged[N], m_tag[N], m_ts[N], m_bad[N];

  always #10 clk = ~clk;

  rail_seq_recorder #(.N_RAILS(N), .TAG_W(TW), .TS_W(SW), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .act_i(act), .uv_cross_i(uv), .off_cross_i(off),
    .thr_sel_i(sel), .tag_ow_en_i(tow), .ts_ow_en_i(sow), .exp_tag_i(expv),
    .seq_irq_en_i(ien), .tag_ack_i(tack), .ts_ack_i(sack),
    .tag_ovf_clr_i(tclr), .ts_ovf_clr_i(sclr),
    .rec_active_o(rec), .phase_o(ph), .tag_log_o(tags), .ts_hi_o(tshi), .ts_lo_o(tslo),
    .tag_rdy_o(trdy), .ts_rdy_o(srdy), .tag_ovf_o(tovf), .ts_ovf_o(sovf), .irq_n_o(irqn)
  );

  task automatic chk(input string req, input string what, input longint act_v, input longint exp_v);
    n_run++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act_v, exp_v, $time);
    end
  endtask

  task automatic model_reset();
    m_actq = 0; m_rec = 0; m_cnt = 0; m_tmr = 0; m_ph = 0; m_close = 0;
    m_tal = 0; m_sal = 0; m_trdy = 0; m_srdy = 0; m_tovf = 0; m_sovf = 0;
    for (int i = 0; i < N; i++) begin
      m_tagged[i] = 0; m_tag[i] = (1 << TW) - 1; m_ts[i] = 0; m_bad[i] = 0;
    end
  endtask

  // behavioural model, one step per clock edge
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int rise, anyev, alltag, anybad, tal_n, sal_n;
      int ev[N];
      rise = (act && !m_actq) ? 1 : 0;
      anyev = 0;
      for (int i = 0; i < N; i++) begin
        int c;
        c = sel[i] ? int'(off[i]) : int'(uv[i]);
        ev[i] = (m_rec && c && !m_tagged[i] && !rise) ? 1 : 0;
        if (ev[i]) anyev = 1;
      end
      alltag = 1; anybad = 0;
      for (int i = 0; i < N; i++) begin
        if (!m_tagged[i]) alltag = 0;
        if (m_bad[i]) anybad = 1;
      end
      tal_n = (tow || !m_trdy) ? 1 : 0;
      sal_n = (sow || !m_srdy) ? 1 : 0;
      if (rise) begin
        for (int i = 0; i < N; i++) begin
          m_tagged[i] = 0; m_bad[i] = 0;
          if (tal_n) m_tag[i] = (1 << TW) - 1;
          if (sal_n) m_ts[i] = 0;
        end
        if (m_trdy) m_tovf = 1; else if (tclr) m_tovf = 0;
        if (m_srdy) m_sovf = 1; else if (sclr) m_sovf = 0;
        m_tal = tal_n; m_sal = sal_n;
        if (tack) m_trdy = 0;
        if (sack) m_srdy = 0;
        m_rec = 1; m_cnt = 0; m_tmr = 0; m_ph = 0; m_close = 0;
      end else begin
        for (int i = 0; i < N; i++) if (ev[i]) begin
          m_tagged[i] = 1;
          if (m_tal) begin
            m_tag[i] = m_cnt;
            m_bad[i] = (m_cnt != int'(expv[i*TW +: TW])) ? 1 : 0;
          end
          if (m_sal) m_ts[i] = m_tmr;
        end
        if (anyev && m_tal) m_trdy = 1; else if (tack) m_trdy = 0;
        if (anyev && m_sal) m_srdy = 1; else if (sack) m_srdy = 0;
        if (tclr) m_tovf = 0;
        if (sclr) m_sovf = 0;
        if (m_close) begin
          m_close = 0;
          m_ph = (alltag && !anybad) ? 1 : 2;
        end
        if (m_rec) begin
          if (m_tmr == TO - 1) begin m_rec = 0; m_close = 1; end
          else m_tmr = m_tmr + 1;
        end
        if (anyev) m_cnt = m_cnt + 1;
      end
      m_actq = act;
    end
  end

  // compare every cycle, well after the edge and after the input changes
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      int anybad;
      anybad = 0;
      for (int i = 0; i < N; i++) if (m_bad[i]) anybad = 1;
      chk("R1", "rec_active", rec, m_rec);
      chk("R9", "phase", ph, m_ph);
      chk("R7", "tag_rdy", trdy, m_trdy);
      chk("R7", "ts_rdy", srdy, m_srdy);
      chk("R5", "tag_ovf", tovf, m_tovf);
      chk("R6", "ts_ovf", sovf, m_sovf);
      chk("R8", "irq_n", irqn, (ien && anybad) ? 0 : 1);
      for (int i = 0; i < N; i++) begin
        chk("R2", $sformatf("tag[%0d]", i), tags[i*TW +: TW], m_tag[i]);
        chk("R4", $sformatf("ts_hi[%0d]", i), tshi[i*HW +: HW], (m_ts[i] >> HW) & ((1 << HW) - 1));
        chk("R4", $sformatf("ts_lo[%0d]", i), tslo[i*HW +: HW], m_ts[i] & ((1 << HW) - 1));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack(input logic t, input logic s, input logic tc, input logic sc);
    tack = t; sack = s; tclr = tc; sclr = sc;
    step(1);
    tack = 0; sack = 0; tclr = 0; sclr = 0;
  endtask

  task automatic start_window();
    act = 0; step(1);
    act = 1; step(1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    expv = {4'd2, 4'd1, 4'd1, 4'd0};
    model_reset();
    step(3);
    #5;
    // R10: reset state at the ports
    chk("R10", "reset tags", tags, {N*TW{1'b1}});
    chk("R10", "reset flags", {rec, trdy, srdy, tovf, sovf, ph}, 0);
    chk("R10", "reset irq_n", irqn, 1);
    rst_n = 1;
    step(2);

    // Window A: correct order, rail1 on the off threshold, rail1 and rail2 share a tag
    sel = 4'b0010;
    start_window();
    chk("R1", "window open", rec, 1);
    step(2); uv[0] = 1;
    step(2); uv[1] = 1;               // unselected input: no tag (R2)
    step(2); off[1] = 1; uv[2] = 1;   // same edge -> same tag (R3)
    step(3); uv[3] = 1;
    step(TO);
    chk("R3", "window A tags", tags, {4'd2, 4'd1, 4'd1, 4'd0});
    chk("R4", "rail0 timestamp", tslo[HW-1:0], 2);
    chk("R9", "window A verdict", ph, 2'b01);
    chk("R8", "window A irq_n", irqn, 1);
    chk("R7", "tag ready", trdy, 1);

    // Window B: tags unread, overwrite off; timestamps acknowledged
    uv = '0; off = '0; act = 0;
    pulse_ack(0, 1, 0, 0);
    start_window();
    chk("R5", "tag overflow", tovf, 1);
    step(1); uv[3] = 1;
    step(1); uv[0] = 1; off[1] = 1; uv[2] = 1;
    step(2);
    chk("R5", "blocked tags kept", tags, {4'd2, 4'd1, 4'd1, 4'd0});
    chk("R8", "blocked no irq", irqn, 1);
    chk("R6", "ts written", srdy, 1);
    step(TO);
    chk("R9", "window B verdict", ph, 2'b01);

    // Window C: rail0 and rail1 together, rail2 missing -> mismatch and bad verdict
    uv = '0; off = '0; act = 0;
    pulse_ack(1, 1, 1, 1);
    chk("R7", "ovf cleared", tovf, 0);
    start_window();
    step(1); uv[0] = 1; off[1] = 1; uv[3] = 1;
    step(2);
    chk("R8", "mismatch irq", irqn, 0);
    ien = 0; step(1);
    chk("R8", "irq disabled", irqn, 1);
    ien = 1;
    tack = 1; step(1); tack = 0;      // acknowledge while idle edge
    step(TO);
    chk("R9", "window C verdict", ph, 2'b10);
    chk("R9", "irq persists", irqn, 0);

    // Window D: overwrite enabled with unread data, then restart mid-window
    uv = '0; off = '0; act = 0;
    tow = 1; sow = 1;
    step(1); uv[2] = 1;
    step(2);
    start_window();
    step(3);
    chk("R2", "level before window tags", tags[2*TW +: TW], 0);
    uv[0] = 1; step(3);
    chk("R6", "ts overflow", sovf, 1);
    start_window();                   // restart with data pending (R1)
    chk("R5", "restart clears tags", tags, {N*TW{1'b1}});
    chk("R5", "restart ovf", tovf, 1);
    step(5); uv[1] = 1; uv[3] = 1; tack = 1; step(1); tack = 0;
    step(TO + 2);
    chk("R9", "window D closed", rec, 0);
    uv[1] = 0; step(3);
    chk("R9", "no tag after close", tags[3*TW +: TW], 1);
    step(4);
    finish_run();
  end

endmodule